// File: doc/BRIEF.md
# Serial Configuration Loader with Identifier and Block Checks

This block takes a bit-serial stream of 16-bit configuration words and writes the useful part into a coefficient and program memory. Words are framed by a frame-sync input. Bits are sampled on the edge of an incoming serial clock that an input selects. The system clock oversamples the serial clock, data and frame-sync through a short synchroniser, so every serial edge is seen as a one-cycle event in the system clock domain.

A load starts with an identifier word. The payload follows as twelve blocks of 42 words. A check word closes each block and is compared with a CRC-16 that the loader computes over that block. Payload words go to the memory in arrival order. The identifier and the check words are never stored. A good load sets the done flag, which tells the rest of the chip that conversion may start. A wrong identifier or a failed check pulls the active-low error flag down. After done or an error, all further words are ignored until a re-arm pulse puts the loader back into its waiting state.

The controller has five states:
- `LD_WAIT_ID` goes to `LD_PAYLOAD` on a correct identifier, or to `LD_REJECTED` on any other word.
- `LD_PAYLOAD` writes each word and moves to `LD_CHECK` after the 42nd word of a block.
- `LD_CHECK` goes back to `LD_PAYLOAD` on a match when blocks remain, to `LD_LOADED` on a match for the last block, and to `LD_REJECTED` on a mismatch.
- `LD_LOADED` and `LD_REJECTED` hold until re-arm.
- Re-arm moves every state to `LD_WAIT_ID`.

Top module: `cfgl_loader`

## Requirements
- R1: After reset, and one clock after `rearm_i` is high, `done_o` is 0, `err_no` is 1 and no write is issued. Re-arm returns the loader to waiting for an identifier and discards any partly received word. A word that completes while `rearm_i` is high is dropped.
- R2: A serial bit is sampled on the rising edge of `sclk_i` when `edge_sel_i` is 0 and on the falling edge when it is 1. A word starts at a sampled bit with `fsync_i` high, which is the word's MSB, and holds the next 15 sampled bits, MSB first. Bits sampled outside a word are ignored.
- R3: The first word after re-arm must equal 0x7725. Any other value drives `err_no` to 0 and nothing is written.
- R4: Payload words are written unchanged in arrival order to addresses 0 up to 503. There is one write per payload word and the address rises by one per write. Identifier and check words are never written.
- R5: The check word after each 42-word block must equal the CRC-16 of that block. The CRC uses polynomial 0x1021 and start value 0xFFFF, processes each word MSB first, has no reflection and no final inversion, and is re-seeded for every block.
- R6: A check mismatch drives `err_no` to 0 and stops all further writes. `done_o` and an asserted error are never both active.
- R7: When the check word of the twelfth block matches, `done_o` goes to 1 and `err_no` stays 1. A full load is 517 words, or 8272 bits, and stores 504 words.
- R8: Once `done_o` is 1 or `err_no` is 0, further framed words cause no write and leave both flags unchanged until re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | Synchronous re-arm pulse, clears flags and restarts the load |
| edge_sel_i | input | 1 | Serial sampling edge: 0 rising, 1 falling |
| sclk_i | input | 1 | Serial clock, oversampled |
| fsync_i | input | 1 | Frame sync, high on the MSB bit of a word |
| sdata_i | input | 1 | Serial data |
| mem_we_o | output | 1 | Memory write strobe, one cycle per payload word |
| mem_addr_o | output | 9 | Memory write address |
| mem_wdata_o | output | 16 | Memory write data |
| done_o | output | 1 | Load complete, conversion may start |
| err_no | output | 1 | Active-low load error flag |

## Verification
Two functions can fall in the same system clock cycle: a re-arm and the completion of a received word. The bench sends a correct identifier and holds `rearm_i` high across the sampling edge of its last bit, so the word completes while re-arm is active. The result is judged at the ports. Both flags must be back at their idle values with no write issued. The next framed word, 0x1234, must then be treated as the identifier, which means the error flag falls and nothing is written. That shows the earlier identifier was dropped and not accepted.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int CFG_W = 16;

    typedef enum logic [2:0] {
        LD_WAIT_ID,
        LD_PAYLOAD,
        LD_CHECK,
        LD_LOADED,
        LD_REJECTED
    } ld_state_e;

    // Advance a CRC register over one word, MSB first, no reflection.
    function automatic logic [CFG_W-1:0] crc_step_word(
        input logic [CFG_W-1:0] crc_in,
        input logic [CFG_W-1:0] din,
        input logic [CFG_W-1:0] poly
    );
        logic [CFG_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            fb = c[CFG_W-1] ^ din[i];
            c  = {c[CFG_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfgl_bit_rx.sv
module cfgl_bit_rx
    import cfgl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             edge_sel_i,
    input  logic             sclk_i,
    input  logic             fsync_i,
    input  logic             sdata_i,
    output logic             word_vld_o,
    output logic [CFG_W-1:0] word_o
);

    localparam int CNT_W = $clog2(CFG_W) + 1;

    logic [SYNC_STAGES:0]   sclk_p;
    logic [SYNC_STAGES-1:0] fs_p;
    logic [SYNC_STAGES-1:0] sd_p;
    logic [CNT_W-1:0]       bit_cnt;
    logic [CFG_W-1:0]       shreg;
    logic                   edge_hit;
    logic                   clk_cur;
    logic                   clk_prev;

    // Data and frame sync pass the same number of stages as the clock.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_p <= '0;
            fs_p   <= '0;
            sd_p   <= '0;
        end else begin
            sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk_i};
            fs_p   <= {fs_p[SYNC_STAGES-2:0], fsync_i};
            sd_p   <= {sd_p[SYNC_STAGES-2:0], sdata_i};
        end
    end

    assign clk_cur  = sclk_p[SYNC_STAGES-1];
    assign clk_prev = sclk_p[SYNC_STAGES];

    always_comb begin
        if (edge_sel_i) edge_hit = clk_prev & ~clk_cur;
        else            edge_hit = ~clk_prev & clk_cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            word_vld_o <= 1'b0;
        end else begin
            word_vld_o <= 1'b0;
            if (flush_i) begin
                bit_cnt <= '0;
            end else if (edge_hit) begin
                if (fs_p[SYNC_STAGES-1]) begin
                    shreg   <= {shreg[CFG_W-2:0], sd_p[SYNC_STAGES-1]};
                    bit_cnt <= CNT_W'(1);
                end else if (bit_cnt != '0) begin
                    shreg <= {shreg[CFG_W-2:0], sd_p[SYNC_STAGES-1]};
                    if (bit_cnt == CNT_W'(CFG_W - 1)) begin
                        bit_cnt    <= '0;
                        word_vld_o <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    assign word_o = shreg;

endmodule

// File: rtl/cfgl_crc16.sv
module cfgl_crc16
    import cfgl_pkg::*;
#(
    parameter logic [CFG_W-1:0] POLY = 16'h1021,
    parameter logic [CFG_W-1:0] INIT = 16'hFFFF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             seed_i,
    input  logic             upd_i,
    input  logic [CFG_W-1:0] data_i,
    output logic [CFG_W-1:0] crc_o
);

    logic [CFG_W-1:0] crc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            crc_q <= INIT;
        end else if (seed_i) begin
            crc_q <= INIT;
        end else if (upd_i) begin
            crc_q <= crc_step_word(crc_q, data_i, POLY);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
    import cfgl_pkg::*;
#(
    parameter logic [CFG_W-1:0] ID_WORD   = 16'h7725,
    parameter int               BLK_WORDS = 42,
    parameter int               NUM_BLKS  = 12,
    parameter int               ADDR_W    = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rearm_i,
    input  logic              word_vld_i,
    input  logic [CFG_W-1:0]  word_i,
    input  logic [CFG_W-1:0]  crc_i,
    output logic              crc_seed_o,
    output logic              crc_upd_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [CFG_W-1:0]  mem_wdata_o,
    output logic              done_o,
    output logic              err_no
);

    localparam int WCNT_W = $clog2(BLK_WORDS);
    localparam int BCNT_W = $clog2(NUM_BLKS);

    ld_state_e         state_q, state_d;
    logic [WCNT_W-1:0] wrd_cnt;
    logic [BCNT_W-1:0] blk_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              take;
    logic              id_ok;
    logic              chk_ok;
    logic              last_wrd;
    logic              last_blk;

    assign take     = word_vld_i & ~rearm_i;
    assign id_ok    = (word_i == ID_WORD);
    assign chk_ok   = (word_i == crc_i);
    assign last_wrd = (wrd_cnt == WCNT_W'(BLK_WORDS - 1));
    assign last_blk = (blk_cnt == BCNT_W'(NUM_BLKS - 1));

    assign crc_upd_o  = take & (state_q == LD_PAYLOAD);
    assign crc_seed_o = rearm_i
                      | (take & (state_q == LD_WAIT_ID) & id_ok)
                      | (take & (state_q == LD_CHECK) & chk_ok);

    always_comb begin
        state_d = state_q;
        if (rearm_i) begin
            state_d = LD_WAIT_ID;
        end else if (word_vld_i) begin
            unique case (state_q)
                LD_WAIT_ID:  state_d = id_ok ? LD_PAYLOAD : LD_REJECTED;
                LD_PAYLOAD:  if (last_wrd) state_d = LD_CHECK;
                LD_CHECK: begin
                    if (!chk_ok)       state_d = LD_REJECTED;
                    else if (last_blk) state_d = LD_LOADED;
                    else               state_d = LD_PAYLOAD;
                end
                LD_LOADED:   state_d = LD_LOADED;
                LD_REJECTED: state_d = LD_REJECTED;
                default:     state_d = LD_REJECTED;
            endcase
        end
    end

    // State register and position counters.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LD_WAIT_ID;
            wrd_cnt <= '0;
            blk_cnt <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rearm_i) begin
                wrd_cnt <= '0;
                blk_cnt <= '0;
                addr_q  <= '0;
            end else if (take && state_q == LD_PAYLOAD) begin
                addr_q  <= addr_q + ADDR_W'(1);
                wrd_cnt <= last_wrd ? '0 : wrd_cnt + WCNT_W'(1);
            end else if (take && state_q == LD_CHECK && chk_ok && !last_blk) begin
                blk_cnt <= blk_cnt + BCNT_W'(1);
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
            done_o      <= 1'b0;
            err_no      <= 1'b1;
        end else begin
            mem_we_o <= 1'b0;
            if (rearm_i) begin
                done_o <= 1'b0;
                err_no <= 1'b1;
            end else if (word_vld_i) begin
                unique case (state_q)
                    LD_WAIT_ID: if (!id_ok) err_no <= 1'b0;
                    LD_PAYLOAD: begin
                        mem_we_o    <= 1'b1;
                        mem_addr_o  <= addr_q;
                        mem_wdata_o <= word_i;
                    end
                    LD_CHECK: begin
                        if (!chk_ok)       err_no <= 1'b0;
                        else if (last_blk) done_o <= 1'b1;
                    end
                    LD_LOADED, LD_REJECTED: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
    import cfgl_pkg::*;
#(
    parameter logic [15:0] ID_WORD     = 16'h7725,
    parameter int          BLK_WORDS   = 42,
    parameter int          NUM_BLKS    = 12,
    parameter logic [15:0] CRC_POLY    = 16'h1021,
    parameter logic [15:0] CRC_INIT    = 16'hFFFF,
    parameter int          SYNC_STAGES = 2,
    localparam int         DEPTH       = BLK_WORDS * NUM_BLKS,
    localparam int         ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rearm_i,
    input  logic              edge_sel_i,
    input  logic              sclk_i,
    input  logic              fsync_i,
    input  logic              sdata_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    output logic              done_o,
    output logic              err_no
);

    logic             word_vld;
    logic [CFG_W-1:0] word;
    logic [CFG_W-1:0] crc_val;
    logic             crc_seed;
    logic             crc_upd;

    cfgl_bit_rx #(
        .SYNC_STAGES (SYNC_STAGES)
    ) rx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (rearm_i),
        .edge_sel_i (edge_sel_i),
        .sclk_i     (sclk_i),
        .fsync_i    (fsync_i),
        .sdata_i    (sdata_i),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    cfgl_crc16 #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) crc_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .seed_i (crc_seed),
        .upd_i  (crc_upd),
        .data_i (word),
        .crc_o  (crc_val)
    );

    cfgl_ctrl #(
        .ID_WORD   (ID_WORD),
        .BLK_WORDS (BLK_WORDS),
        .NUM_BLKS  (NUM_BLKS),
        .ADDR_W    (ADDR_W)
    ) ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rearm_i     (rearm_i),
        .word_vld_i  (word_vld),
        .word_i      (word),
        .crc_i       (crc_val),
        .crc_seed_o  (crc_seed),
        .crc_upd_o   (crc_upd),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .done_o      (done_o),
        .err_no      (err_no)
    );

endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk #(
    parameter int ADDR_W = 9,
    parameter int DEPTH  = 504
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rearm_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              done_o,
    input logic              err_no
);

    logic              seen_wr;
    logic [ADDR_W-1:0] last_addr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_wr   <= 1'b0;
            last_addr <= '0;
        end else if (rearm_i) begin
            seen_wr   <= 1'b0;
        end else if (mem_we_o) begin
            seen_wr   <= 1'b1;
            last_addr <= mem_addr_o;
        end
    end

    AST_REARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) rearm_i |=> (err_no && !done_o && !mem_we_o)); // R1
    AST_FIRST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni) (mem_we_o && !seen_wr) |-> (mem_addr_o == '0)); // R4
    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (mem_we_o && seen_wr) |-> (mem_addr_o == last_addr + ADDR_W'(1))); // R4
    AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we_o |-> (int'(mem_addr_o) < DEPTH)); // R4
    AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(done_o && !err_no)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o && !rearm_i) |=> done_o); // R7
    AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (!err_no && !rearm_i) |=> !err_no); // R8
    AST_NO_WR_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni) (done_o || !err_no) |-> !mem_we_o); // R8

endmodule

bind cfgl_loader cfgl_loader_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rearm_i    (rearm_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o),
    .err_no     (err_no)
);

// File: tb/cfgl_loader_tb_top.sv
module cfgl_loader_tb_top;

    typedef struct packed {
        logic        edge_mode;
        logic [1:0]  fault;      // 0 none, 1 bad identifier, 2 bad check word
        logic [3:0]  fault_blk;
        logic [15:0] seed;
        logic        exp_done;
        logic        exp_err_n;
        logic [9:0]  exp_wr;
    } scn_t;

    localparam int NSCN = 6;
    localparam scn_t SCN [NSCN] = '{
        '{1'b0, 2'd0, 4'd0,  16'h1357, 1'b1, 1'b1, 10'd504},
        '{1'b1, 2'd0, 4'd0,  16'hBEEF, 1'b1, 1'b1, 10'd504},
        '{1'b0, 2'd1, 4'd0,  16'h0000, 1'b0, 1'b0, 10'd0},
        '{1'b1, 2'd2, 4'd0,  16'h4242, 1'b0, 1'b0, 10'd42},
        '{1'b0, 2'd2, 4'd11, 16'h0F0F, 1'b0, 1'b0, 10'd504},
        '{1'b0, 2'd2, 4'd5,  16'hA5C3, 1'b0, 1'b0, 10'd252}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rearm = 1'b0;
    logic        edge_mode = 1'b0;
    logic        sclk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic        mem_we;
    logic [8:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        done;
    logic        err_n;

    int          n_chk = 0;
    int          n_fail = 0;
    int          wr_cnt = 0;
    int          wr_bad = 0;
    logic [15:0] cur_seed = 16'h0;

    always #5 clk = ~clk;

    cfgl_loader dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rearm_i     (rearm),
        .edge_sel_i  (edge_mode),
        .sclk_i      (sclk),
        .fsync_i     (fsync),
        .sdata_i     (sdata),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .done_o      (done),
        .err_no      (err_n)
    );

    function automatic logic [15:0] pay(input logic [15:0] seed, input int idx);
        return 16'(idx * 40503 + int'(seed)) ^ 16'(idx >> 3);
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r;
        r = c;
        for (int k = 15; k >= 0; k--) begin
            if (r[15] != w[k]) r = (r << 1) ^ 16'h1021;
            else               r = r << 1;
        end
        return r;
    endfunction

    // Write monitor: order and data of every memory write.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (int'(mem_addr) != wr_cnt || mem_wdata != pay(cur_seed, wr_cnt))
                wr_bad = wr_bad + 1;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic f);
        @(negedge clk);
        sclk  = edge_mode ? 1'b1 : 1'b0;
        sdata = b;
        fsync = f;
        repeat (2) @(negedge clk);
        sclk = edge_mode ? 1'b0 : 1'b1;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i], i == 15);
    endtask

    task automatic do_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        wr_cnt = 0;
        wr_bad = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_scn(input scn_t s);
        logic [15:0] crc;
        logic        stop;
        int          wr_before;
        do_rearm();
        chk(err_n == 1'b1 && done == 1'b0, "R1 flags after rearm", {done, err_n}, 2'b01);
        edge_mode = s.edge_mode;
        cur_seed  = s.seed;
        stop      = 1'b0;
        send_word(s.fault == 2'd1 ? 16'h7724 : 16'h7725);
        if (s.fault == 2'd1) stop = 1'b1;
        for (int b = 0; b < 12; b++) begin
            if (!stop) begin
                crc = 16'hFFFF;
                for (int w = 0; w < 42; w++) begin
                    crc = ref_crc(crc, pay(s.seed, b * 42 + w));
                    send_word(pay(s.seed, b * 42 + w));
                end
                if (s.fault == 2'd2 && int'(s.fault_blk) == b) begin
                    send_word(crc ^ 16'h0001);
                    stop = 1'b1;
                end else begin
                    send_word(crc);
                end
            end
        end
        repeat (16) @(negedge clk);
        chk(done == s.exp_done, "R7/R3/R6 done flag", done, s.exp_done);
        chk(err_n == s.exp_err_n, "R3/R5/R6 error flag", err_n, s.exp_err_n);
        chk(wr_cnt == int'(s.exp_wr), "R4/R6 write count", wr_cnt, s.exp_wr);
        chk(wr_bad == 0, "R4/R5 write order and data", wr_bad, 0);
        // R8: trailing framed words after the load has ended
        wr_before = wr_cnt;
        send_word(16'h7725);
        send_word(pay(s.seed, 0));
        send_word(16'hFFFF);
        repeat (16) @(negedge clk);
        chk(wr_cnt == wr_before, "R8 no write after end", wr_cnt, wr_before);
        chk(done == s.exp_done && err_n == s.exp_err_n, "R8 flags held",
            {done, err_n}, {s.exp_done, s.exp_err_n});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && err_n == 1'b1 && mem_we == 1'b0, "R1 reset state",
            {done, err_n, mem_we}, 3'b010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: bits sampled with no frame sync are ignored
        do_rearm();
        for (int i = 15; i >= 0; i--) send_bit(1'(16'h1234 >> i), 1'b0);
        repeat (16) @(negedge clk);
        chk(err_n == 1'b1 && wr_cnt == 0, "R2 unframed bits ignored", {err_n, 1'b0}, 2'b10);

        // Vector table: full loads, both edges, identifier and check faults
        for (int s = 0; s < NSCN; s++) run_scn(SCN[s]);

        // R1: rearm held across completion of the identifier word
        do_rearm();
        edge_mode = 1'b0;
        for (int i = 15; i >= 1; i--) send_bit(1'(16'h7725 >> i), i == 15);
        @(negedge clk);
        sclk  = 1'b0;
        sdata = 1'b1;
        fsync = 1'b0;
        rearm = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (6) @(negedge clk);
        rearm  = 1'b0;
        wr_cnt = 0;
        repeat (4) @(negedge clk);
        chk(err_n == 1'b1 && done == 1'b0 && wr_cnt == 0, "R1 collision flags",
            {done, err_n}, 2'b01);
        send_word(16'h1234);
        repeat (16) @(negedge clk);
        chk(err_n == 1'b0, "R1/R3 dropped identifier, next word judged as identifier", err_n, 0);
        chk(wr_cnt == 0, "R3 nothing written after bad identifier", wr_cnt, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule